// File: doc/BRIEF.md
# Floating-Point Register Upper-Half Mover

This block holds a 32-entry floating-point register file and carries out the two coprocessor-1 moves that transfer the upper 32 bits of a register to or from the integer side. One move copies the upper half of a floating-point register out to an integer destination, sign-extended to 64 bits. The other move writes the low 32 bits of an integer operand into the upper half of a floating-point register. A mode input sets the register width. In wide mode every register is 64 bits. In narrow mode each register holds 32 bits, and the upper half of an even register is held in the odd register that follows it.

The pipeline front end hands the block one decoded-or-not instruction word per cycle, together with the integer operand and the mode. The block decides on its own whether the word is one of the two moves. A read move returns its result, the destination index and a valid strobe one cycle after the request. A write move updates storage at the clock edge where it is accepted. A combinational debug port shows the contents of any entry. In narrow mode an odd register number does not fault: a read returns a fixed marker and a write stores a fixed marker.

A small state machine follows the last accepted operation. It has three states. ST_IDLE is entered when the last cycle carried no move. ST_FROM is entered after a read move and drives the valid strobe. ST_TO is entered after a write move. The transition into each state depends only on the operation accepted in the cycle before, so any state can go to any of the three.

Top module: `fhm_unit`

## Requirements
- R1: Only a word with req_valid high, bits [31:26] = 010001, bits [25:21] equal to 00011 (read move) or 00111 (write move) and bits [10:0] all zero takes effect. Any other word writes no register, raises no valid and leaves res_data unchanged.
- R2: For a read move in wide mode (wide_mode = 1), the cycle after the request shows res_valid = 1, res_data = bits [63:32] of entry fs (bits [15:11]) sign-extended to 64 bits, and res_gpr = bits [20:16] of the request.
- R3: For a read move in narrow mode with an even fs, res_data is bits [31:0] of entry fs+1, sign-extended to 64 bits.
- R4: For a read move in narrow mode with an odd fs, res_data is 0x000000000BADF00D.
- R5: A write move in wide mode sets bits [63:32] of entry fs to gpr_lo and leaves bits [31:0] unchanged.
- R6: A write move in narrow mode with an even fs sets entry fs+1 to gpr_lo, zero-extended. Entry fs is left unchanged.
- R7: A write move in narrow mode with an odd fs sets entry fs to 0x00000000DEADC0DE, whatever gpr_lo holds.
- R8: Reset clears every entry, res_data, res_gpr and res_valid.
- R9: res_valid is high only in the single cycle after an accepted read move. In every other cycle res_data and res_gpr keep their last value.
- R10: A read move issued in the cycle right after a write move to the same entry returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| gpr_lo | input | 32 | Low half of the integer operand for a write move |
| wide_mode | input | 1 | 1 = 64-bit registers, 0 = 32-bit paired registers |
| dbg_idx | input | 5 | Entry shown on dbg_data |
| res_data | output | 64 | Sign-extended read-move result |
| res_gpr | output | 5 | Integer destination index of the result |
| res_valid | output | 1 | Result strobe, one cycle after a read move |
| dbg_data | output | 64 | Contents of entry dbg_idx |

## Verification
A wrong state or a wrong transition shows up on res_valid in the cycle right after the request. The strobe is either missing after a read move or present after a write move or an illegal word. A corrupted storage entry cannot be seen until it is read. The debug port exposes it combinationally in the cycle after the write edge, and a later read move exposes it one cycle after that read. A broken pairing rule or a wrong marker value therefore shows up either on the debug port or in the result of the next read move aimed at that entry.

// File: rtl/fhm_pkg.sv
package fhm_pkg;
    localparam logic [5:0] MAJOR_COP1 = 6'b010001;
    localparam logic [4:0] SUB_FROM   = 5'b00011;
    localparam logic [4:0] SUB_TO     = 5'b00111;

    localparam logic [31:0] MARK_READ  = 32'h0BADF00D;
    localparam logic [31:0] MARK_WRITE = 32'hDEADC0DE;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_FROM = 2'd1,
        OP_TO   = 2'd2
    } move_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FROM = 2'd1,
        ST_TO   = 2'd2
    } move_st_e;
endpackage

// File: rtl/fhm_decode.sv
module fhm_decode
    import fhm_pkg::*;
(
    input  logic        req_valid,
    input  logic [31:0] instr,
    output move_op_e    op,
    output logic [4:0]  fs,
    output logic [4:0]  rt
);
    logic frame_ok;

    always_comb begin
        frame_ok = req_valid && (instr[31:26] == MAJOR_COP1) && (instr[10:0] == 11'd0);
        fs       = instr[15:11];
        rt       = instr[20:16];
        op       = OP_NONE;
        if (frame_ok) begin
            if (instr[25:21] == SUB_FROM)
                op = OP_FROM;
            else if (instr[25:21] == SUB_TO)
                op = OP_TO;
        end
    end
endmodule

// File: rtl/fhm_regfile.sv
module fhm_regfile #(
    parameter int NREG = 32,
    parameter int XLEN = 64,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr,
    output logic [XLEN-1:0] rdata,
    input  logic [AW-1:0]   dbg_addr,
    output logic [XLEN-1:0] dbg_rdata
);
    logic [XLEN-1:0] cells [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)
                cells[g] <= '0;
            else if (we && (waddr == AW'(g)))
                cells[g] <= wdata;
        end
    end

    assign rdata     = cells[raddr];
    assign dbg_rdata = cells[dbg_addr];
endmodule

// File: rtl/fhm_datapath.sv
module fhm_datapath
    import fhm_pkg::*;
#(
    parameter int NREG = 32,
    parameter int XLEN = 64,
    parameter logic [XLEN/2-1:0] RD_MARK = MARK_READ,
    parameter logic [XLEN/2-1:0] WR_MARK = MARK_WRITE,
    localparam int AW   = $clog2(NREG),
    localparam int HALF = XLEN / 2
) (
    input  move_op_e        op,
    input  logic [AW-1:0]   fs,
    input  logic            wide,
    input  logic [HALF-1:0] gpr_lo,
    input  logic [XLEN-1:0] entry,
    output logic [AW-1:0]   raddr,
    output logic            we,
    output logic [AW-1:0]   waddr,
    output logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] result
);
    logic [AW-1:0]   partner;
    logic            odd;
    logic [HALF-1:0] upper;

    always_comb begin
        partner = {fs[AW-1:1], 1'b1};
        odd     = fs[0];
        raddr   = wide ? fs : partner;
        we      = 1'b0;
        waddr   = fs;
        wdata   = '0;
        upper   = '0;
        result  = '0;
        unique case (op)
            OP_TO: begin
                we = 1'b1;
                if (wide) begin
                    wdata = {gpr_lo, entry[HALF-1:0]};
                end else if (!odd) begin
                    waddr = partner;
                    wdata = {{HALF{1'b0}}, gpr_lo};
                end else begin
                    wdata = {{HALF{1'b0}}, WR_MARK};
                end
            end
            OP_FROM: begin
                if (wide)
                    upper = entry[XLEN-1:HALF];
                else if (odd)
                    upper = RD_MARK;
                else
                    upper = entry[HALF-1:0];
                result = {{HALF{upper[HALF-1]}}, upper};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fhm_unit.sv
module fhm_unit
    import fhm_pkg::*;
#(
    parameter int NREG = 32,
    parameter int XLEN = 64,
    localparam int AW   = $clog2(NREG),
    localparam int HALF = XLEN / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [31:0]     instr,
    input  logic [HALF-1:0] gpr_lo,
    input  logic            wide_mode,
    input  logic [AW-1:0]   dbg_idx,
    output logic [XLEN-1:0] res_data,
    output logic [4:0]      res_gpr,
    output logic            res_valid,
    output logic [XLEN-1:0] dbg_data
);
    move_op_e        op;
    logic [4:0]      fs_raw;
    logic [4:0]      rt_raw;
    logic [AW-1:0]   raddr;
    logic [XLEN-1:0] entry;
    logic            we;
    logic [AW-1:0]   waddr;
    logic [XLEN-1:0] wdata;
    logic [XLEN-1:0] result;
    move_st_e        state, state_nx;

    fhm_decode u_dec (
        .req_valid (req_valid),
        .instr     (instr),
        .op        (op),
        .fs        (fs_raw),
        .rt        (rt_raw)
    );

    fhm_datapath #(.NREG(NREG), .XLEN(XLEN)) u_dp (
        .op     (op),
        .fs     (AW'(fs_raw)),
        .wide   (wide_mode),
        .gpr_lo (gpr_lo),
        .entry  (entry),
        .raddr  (raddr),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wdata),
        .result (result)
    );

    fhm_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we),
        .waddr     (waddr),
        .wdata     (wdata),
        .raddr     (raddr),
        .rdata     (entry),
        .dbg_addr  (dbg_idx),
        .dbg_rdata (dbg_data)
    );

    always_comb begin
        unique case (op)
            OP_FROM: state_nx = ST_FROM;
            OP_TO:   state_nx = ST_TO;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data <= '0;
            res_gpr  <= '0;
        end else if (op == OP_FROM) begin
            res_data <= result;
            res_gpr  <= rt_raw;
        end
    end

    assign res_valid = (state == ST_FROM);
endmodule

// File: rtl/fhm_unit_chk.sv
module fhm_unit_chk #(
    parameter int NREG = 32,
    parameter int XLEN = 64,
    localparam int AW   = $clog2(NREG),
    localparam int HALF = XLEN / 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [31:0]     instr,
    input logic [HALF-1:0] gpr_lo,
    input logic            wide_mode,
    input logic [AW-1:0]   dbg_idx,
    input logic [XLEN-1:0] res_data,
    input logic [4:0]      res_gpr,
    input logic            res_valid,
    input logic [XLEN-1:0] dbg_data
);
    logic          shaped;
    logic          is_rd;
    logic          is_wr;
    logic [AW-1:0] tgt;
    logic [AW-1:0] mate;

    assign shaped = req_valid && instr[31:26] == 6'b010001 && instr[10:0] == 11'd0;
    assign is_rd  = shaped && instr[25:21] == 5'b00011;
    assign is_wr  = shaped && instr[25:21] == 5'b00111;
    assign tgt    = AW'(instr[15:11]);
    assign mate   = {tgt[AW-1:1], 1'b1};

    AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> res_valid && res_gpr == $past(instr[20:16])); // R2
    AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> !res_valid); // R1
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> $stable(res_data) && $stable(res_gpr)); // R9
    AST_ODD_READ_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd && !wide_mode && instr[11] |=> res_data == XLEN'(32'h0BADF00D)); // R4
    AST_WIDE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr && wide_mode && dbg_idx == tgt |=>
        (!$stable(dbg_idx) || dbg_data == {$past(gpr_lo), $past(dbg_data[HALF-1:0])})); // R5
    AST_PAIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr && !wide_mode && !instr[11] && dbg_idx == mate |=>
        (!$stable(dbg_idx) || dbg_data == XLEN'($past(gpr_lo)))); // R6
    AST_ODD_WRITE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr && !wide_mode && instr[11] && dbg_idx == tgt |=>
        (!$stable(dbg_idx) || dbg_data == XLEN'(32'hDEADC0DE))); // R7
endmodule

bind fhm_unit fhm_unit_chk #(.NREG(NREG), .XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .instr     (instr),
    .gpr_lo    (gpr_lo),
    .wide_mode (wide_mode),
    .dbg_idx   (dbg_idx),
    .res_data  (res_data),
    .res_gpr   (res_gpr),
    .res_valid (res_valid),
    .dbg_data  (dbg_data)
);

// File: tb/sim_fhm_unit.sv
module sim_fhm_unit;
    localparam int PERIOD = 10;
    localparam int NV = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] gpr_lo = '0;
    logic        wide_mode = 1'b1;
    logic [4:0]  dbg_idx = '0;
    logic [63:0] res_data;
    logic [4:0]  res_gpr;
    logic        res_valid;
    logic [63:0] dbg_data;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // op: 1 = read move, 2 = write move, 0 = malformed write move (bit 0 set)
    // {op[1:0], wide, fs[4:0], gpr[31:0], expected res_data[63:0]}
    localparam logic [103:0] VECS [NV] = '{
        {2'd2, 1'b1, 5'd4,  32'h80001234, 64'h0},
        {2'd1, 1'b1, 5'd4,  32'h0,        64'hFFFFFFFF80001234},
        {2'd0, 1'b1, 5'd4,  32'hFFFFFFFF, 64'hFFFFFFFF80001234},
        {2'd1, 1'b1, 5'd4,  32'h0,        64'hFFFFFFFF80001234},
        {2'd2, 1'b0, 5'd6,  32'h76543210, 64'h0},
        {2'd1, 1'b0, 5'd6,  32'h0,        64'h0000000076543210},
        {2'd1, 1'b0, 5'd7,  32'h0,        64'h000000000BADF00D},
        {2'd2, 1'b0, 5'd9,  32'h12345678, 64'h0},
        {2'd1, 1'b1, 5'd9,  32'h0,        64'h0},
        {2'd2, 1'b0, 5'd8,  32'hFEDCBA98, 64'h0},
        {2'd1, 1'b0, 5'd8,  32'h0,        64'hFFFFFFFFFEDCBA98},
        {2'd2, 1'b1, 5'd31, 32'h13579BDF, 64'h0},
        {2'd1, 1'b1, 5'd31, 32'h0,        64'h0000000013579BDF},
        {2'd2, 1'b0, 5'd2,  32'hAAAA5555, 64'h0},
        {2'd2, 1'b1, 5'd3,  32'h11112222, 64'h0},
        {2'd1, 1'b1, 5'd3,  32'h0,        64'h0000000011112222},
        {2'd1, 1'b0, 5'd2,  32'h0,        64'hFFFFFFFFAAAA5555}
    };

    fhm_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .instr     (instr),
        .gpr_lo    (gpr_lo),
        .wide_mode (wide_mode),
        .dbg_idx   (dbg_idx),
        .res_data  (res_data),
        .res_gpr   (res_gpr),
        .res_valid (res_valid),
        .dbg_data  (dbg_data)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [31:0] enc(input logic [5:0] major, input logic [4:0] sub,
                                        input logic [4:0] rt, input logic [4:0] fs,
                                        input logic [10:0] tail);
        return {major, sub, rt, fs, tail};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at negedge, return a quarter period after the next rising edge
    task automatic issue(input logic v, input logic [31:0] w, input logic [31:0] g,
                         input logic wd);
        @(negedge clk);
        req_valid = v;
        instr     = w;
        gpr_lo    = g;
        wide_mode = wd;
        @(posedge clk);
        #(PERIOD/4);
        req_valid = 1'b0;
    endtask

    task automatic peek(input logic [4:0] idx, input logic [63:0] exp, input string tag);
        dbg_idx = idx;
        #1;
        check(dbg_data === exp, tag, dbg_data, exp);
    endtask

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        // R8: reset state
        repeat (3) @(posedge clk);
        #(PERIOD/4);
        check(res_valid === 1'b0, "R8 valid", {63'd0, res_valid}, 64'd0);
        check(res_data === 64'd0, "R8 data", res_data, 64'd0);
        for (int i = 0; i < 32; i++) peek(5'(i), 64'd0, "R8 entry");
        @(negedge clk);
        rst_n = 1'b1;

        // table walk: R2 R3 R4 R9, R1 (malformed word), R10 (read right after write)
        for (int k = 0; k < NV; k++) begin
            logic [1:0]  op;
            logic        wd;
            logic [4:0]  fs;
            logic [31:0] g;
            logic [63:0] exp;
            {op, wd, fs, g, exp} = VECS[k];
            case (op)
                2'd1: issue(1'b1, enc(6'b010001, 5'b00011, 5'(k), fs, 11'd0), g, wd);
                2'd2: issue(1'b1, enc(6'b010001, 5'b00111, 5'd0, fs, 11'd0), g, wd);
                default: issue(1'b1, enc(6'b010001, 5'b00111, 5'd0, fs, 11'd1), g, wd);
            endcase
            if (op == 2'd1) begin
                string tag;
                tag = wd ? "R2 read" : (fs[0] ? "R4 read" : "R3 read");
                check(res_valid === 1'b1, tag, {63'd0, res_valid}, 64'd1);
                check(res_data === exp, tag, res_data, exp);
                check(res_gpr === 5'(k), "R2 dest", {59'd0, res_gpr}, 64'(5'(k)));
            end else if (op == 2'd0) begin
                check(res_valid === 1'b0, "R1 valid", {63'd0, res_valid}, 64'd0);
                check(res_data === exp, "R1 data", res_data, exp);
            end else begin
                check(res_valid === 1'b0, "R9 valid", {63'd0, res_valid}, 64'd0);
            end
        end

        // storage contents after the table
        peek(5'd3, 64'h11112222AAAA5555, "R5 keep low");
        peek(5'd4, 64'h8000123400000000, "R1 no write");
        peek(5'd7, 64'h0000000076543210, "R6 pair");
        peek(5'd6, 64'd0, "R6 even kept");
        peek(5'd2, 64'd0, "R6 even kept");
        peek(5'd9, 64'h00000000FEDCBA98, "R6 pair");

        // R7: odd register in narrow mode gets the marker
        issue(1'b1, enc(6'b010001, 5'b00111, 5'd0, 5'd13, 11'd0), 32'h55555555, 1'b0);
        peek(5'd13, 64'h00000000DEADC0DE, "R7 mark");
        peek(5'd12, 64'd0, "R7 even kept");

        // R1: other malformed or absent words
        held = res_data;
        issue(1'b0, enc(6'b010001, 5'b00011, 5'd1, 5'd4, 11'd0), 32'd0, 1'b1);
        check(res_valid === 1'b0, "R1 no req", {63'd0, res_valid}, 64'd0);
        check(res_data === held, "R1 no req data", res_data, held);
        issue(1'b1, enc(6'b010010, 5'b00111, 5'd0, 5'd20, 11'd0), 32'h99999999, 1'b1);
        peek(5'd20, 64'd0, "R1 major");
        issue(1'b1, enc(6'b010001, 5'b00100, 5'd0, 5'd22, 11'd0), 32'h77777777, 1'b0);
        peek(5'd23, 64'd0, "R1 sub");

        // R9: result and index hold across an idle cycle after a read
        issue(1'b1, enc(6'b010001, 5'b00011, 5'd17, 5'd3, 11'd0), 32'd0, 1'b1);
        issue(1'b0, 32'd0, 32'd0, 1'b1);
        check(res_valid === 1'b0, "R9 pulse", {63'd0, res_valid}, 64'd0);
        check(res_data === 64'h0000000011112222, "R9 hold", res_data, 64'h0000000011112222);
        check(res_gpr === 5'd17, "R9 dest hold", {59'd0, res_gpr}, 64'd17);

        // R10: back-to-back narrow write then read of the same pair
        issue(1'b1, enc(6'b010001, 5'b00111, 5'd0, 5'd10, 11'd0), 32'h80000001, 1'b0);
        issue(1'b1, enc(6'b010001, 5'b00011, 5'd5, 5'd10, 11'd0), 32'd0, 1'b0);
        check(res_data === 64'hFFFFFFFF80000001, "R10 fresh", res_data, 64'hFFFFFFFF80000001);

        // R8: reset in the middle clears storage and outputs
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #(PERIOD/4);
        check(res_data === 64'd0, "R8 mid data", res_data, 64'd0);
        check(res_valid === 1'b0, "R8 mid valid", {63'd0, res_valid}, 64'd0);
        peek(5'd3, 64'd0, "R8 mid entry");
        peek(5'd31, 64'd0, "R8 mid entry");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule